// File: doc/BRIEF.md
# Field-Synchronous Picture-Control Register Bank

This block holds the picture-control settings of a video encoder. The settings are two closed-caption data bytes, a luma offset (brightness), a luma gain (contrast), a hue shift, a gain for each of the two colour-difference channels, and a one-bit gamma-curve select. Each setting is kept twice. A staging copy is written by the host through a plain address/data/strobe port. A live copy drives the video datapath.

With field buffering enabled, the live copies never change during a picture. All staged values move into the live copies together, once per field, in the cycle after a falling edge of the vertical sync input has been detected. That edge is detected on a two-flop synchronized copy of the input. With buffering disabled, a host write reaches the live copy in the same clock edge that captures it in the staging copy. Host reads return the staging copies. A control register selects the buffering mode and reports whether staged values are still waiting for a field boundary.

The host port has no handshake. A strobe is accepted in every cycle, so no back-pressure exists. The read port is combinational.

Top module: `pcr_field_regs`

## Requirements
- R1: After reset the staging and live copies hold these defaults: both caption bytes 0, brightness 0, contrast 0x80, hue 0, both colour gains 0x80, gamma select 0. The buffering enable is 1 and the pending flag is 0.
- R2: The vertical sync input passes through two synchronizing flops. If the input falls between rising edges k-1 and k, the live copies load at rising edge k+2 and show the new values after it. A rising vsync edge causes no load, and each falling edge causes exactly one load.
- R3: While buffering is enabled, host writes change only staging copies. The live outputs stay unchanged until the next load.
- R4: At a load, every live copy takes its staging value in the same clock.
- R5: A host write in the same clock as a load is stored in the staging copy. The live copy takes the old staged value at that load and takes the new value at the next field's load.
- R6: While buffering is disabled, a write to a setting updates its live output at the clock edge that samples the strobe.
- R7: Address 0 is control. Write data bit 0 sets the buffering enable. Read bit 0 is the enable and read bit 1 is the pending flag. Pending is set by a write to a setting while buffering is enabled. It is cleared at a load unless a write happens in the same clock. It is held at 0 while buffering is disabled.
- R8: Addresses 1 to 8 are, in order: caption byte 0, caption byte 1, brightness, contrast, hue, U gain, V gain, gamma select. A read of one of them returns its staging value. A read of any other address returns 0. A write to any other address changes nothing.
- R9: Gamma select stores only write data bit 0 and reads back with all other bits 0.
- R10: While buffering is disabled, each live copy follows its staging copy one clock later. Turning buffering off therefore pushes any values still staged to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_in | input | 1 | Asynchronous vertical sync |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Host read data (staging copies / control) |
| act_cc0 | output | DATA_W | Live caption byte 0 |
| act_cc1 | output | DATA_W | Live caption byte 1 |
| act_bright | output | DATA_W | Live brightness |
| act_contrast | output | DATA_W | Live contrast |
| act_hue | output | DATA_W | Live hue |
| act_ugain | output | DATA_W | Live U gain |
| act_vgain | output | DATA_W | Live V gain |
| act_gamma_sel | output | 1 | Live gamma-curve select |

## Verification
The bench builds the block with its default widths: 8-bit data and 4-bit addresses. These widths give the half-scale defaults of 0x80. The 4-bit address reaches unmapped locations 9 to 15, so writes and reads to unused addresses are exercised. Random traffic mixes vsync toggles with writes and mode changes, so some writes fall on a load cycle by chance. Directed cases pin down the exact load cycle and the write that coincides with a load.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  // number of full-width settings; gamma select is kept separately
  localparam int NUM_WIDE   = 7;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_FIRST  = 1;   // first full-width setting
  localparam int ADR_GAMMA  = ADR_FIRST + NUM_WIDE;

  // full-width slots whose default is half scale (contrast, U gain, V gain)
  function automatic bit slot_is_mid(input int idx);
    return (idx == 3) || (idx == 5) || (idx == 6);
  endfunction
endpackage

// File: rtl/pcr_vsync_edge.sv
module pcr_vsync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_in,
  output logic commit
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], vsync_in};
  end

  // falling edge of the synchronized copy
  assign commit = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R2
endmodule

// File: rtl/pcr_reg_slot.sv
module pcr_reg_slot #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dbuf_en,
  input  logic         commit,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      shadow_q <= RST_VAL;
    else if (wr_hit) shadow_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          active_q <= RST_VAL;
    else if (!dbuf_en)   active_q <= wr_hit ? wr_data : shadow_q;
    else if (commit)     active_q <= shadow_q;
  end

  AST_HOLD_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !commit) |=> $stable(active_q)); // R3
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && commit) |=> (active_q == $past(shadow_q))); // R4
  AST_BYPASS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbuf_en && wr_hit) |=> (active_q == $past(wr_data))); // R6
  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbuf_en && !wr_hit) |=> (active_q == $past(shadow_q))); // R10
endmodule

// File: rtl/pcr_read_mux.sv
module pcr_read_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]                    rd_addr,
  input  logic [pcr_pkg::NUM_WIDE-1:0][DATA_W-1:0] wide_shadow,
  input  logic                                 gamma_shadow,
  input  logic                                 dbuf_en,
  input  logic                                 pending,
  output logic [DATA_W-1:0]                    rd_data
);
  import pcr_pkg::*;

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == ADR_CTRL) begin
      rd_data[0] = dbuf_en;
      rd_data[1] = pending;
    end else if (int'(rd_addr) == ADR_GAMMA) begin
      rd_data[0] = gamma_shadow;
    end else begin
      for (int i = 0; i < NUM_WIDE; i++)
        if (int'(rd_addr) == ADR_FIRST + i) rd_data = wide_shadow[i];
    end
  end
endmodule

// File: rtl/pcr_field_regs.sv
module pcr_field_regs #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] act_cc0,
  output logic [DATA_W-1:0] act_cc1,
  output logic [DATA_W-1:0] act_bright,
  output logic [DATA_W-1:0] act_contrast,
  output logic [DATA_W-1:0] act_hue,
  output logic [DATA_W-1:0] act_ugain,
  output logic [DATA_W-1:0] act_vgain,
  output logic              act_gamma_sel
);
  import pcr_pkg::*;

  localparam logic [DATA_W-1:0] MID_VAL  = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] ZERO_VAL = '0;

  logic commit;
  logic dbuf_en;
  logic pending;
  logic [NUM_WIDE-1:0]             wide_hit;
  logic                            gamma_hit;
  logic                            any_hit;
  logic [NUM_WIDE-1:0][DATA_W-1:0] wide_shadow;
  logic [NUM_WIDE-1:0][DATA_W-1:0] wide_active;
  logic                            gamma_shadow;

  pcr_vsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .commit(commit)
  );

  // address decode
  always_comb begin
    for (int i = 0; i < NUM_WIDE; i++)
      wide_hit[i] = wr_en && (int'(wr_addr) == ADR_FIRST + i);
  end
  assign gamma_hit = wr_en && (int'(wr_addr) == ADR_GAMMA);
  assign any_hit   = (|wide_hit) | gamma_hit;

  // control: buffering enable and pending flag
  always_ff @(posedge clk) begin
    if (!rst_n)                                          dbuf_en <= 1'b1;
    else if (wr_en && int'(wr_addr) == ADR_CTRL)         dbuf_en <= wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !dbuf_en) pending <= 1'b0;
    else if (any_hit)       pending <= 1'b1;
    else if (commit)        pending <= 1'b0;
  end

  generate
    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
      pcr_reg_slot #(
        .W(DATA_W),
        .RST_VAL(slot_is_mid(g) ? MID_VAL : ZERO_VAL)
      ) u_slot (
        .clk(clk), .rst_n(rst_n), .dbuf_en(dbuf_en), .commit(commit),
        .wr_hit(wide_hit[g]), .wr_data(wr_data),
        .shadow_q(wide_shadow[g]), .active_q(wide_active[g])
      );
    end
  endgenerate

  pcr_reg_slot #(.W(1), .RST_VAL(1'b0)) u_gamma (
    .clk(clk), .rst_n(rst_n), .dbuf_en(dbuf_en), .commit(commit),
    .wr_hit(gamma_hit), .wr_data(wr_data[0]),
    .shadow_q(gamma_shadow), .active_q(act_gamma_sel)
  );

  pcr_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rd_addr(rd_addr), .wide_shadow(wide_shadow), .gamma_shadow(gamma_shadow),
    .dbuf_en(dbuf_en), .pending(pending), .rd_data(rd_data)
  );

  assign act_cc0      = wide_active[0];
  assign act_cc1      = wide_active[1];
  assign act_bright   = wide_active[2];
  assign act_contrast = wide_active[3];
  assign act_hue      = wide_active[4];
  assign act_ugain    = wide_active[5];
  assign act_vgain    = wide_active[6];

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !any_hit) |=> !pending); // R7
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && any_hit && !(wr_en && int'(wr_addr) == ADR_CTRL)) |=> pending); // R7
  AST_PEND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dbuf_en |=> !pending); // R7
endmodule

// File: tb/tb_pcr_field_regs.sv
module tb_pcr_field_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_in = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] act_cc0, act_cc1, act_bright, act_contrast, act_hue, act_ugain, act_vgain;
  logic act_gamma_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcr_field_regs dut (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .act_cc0(act_cc0), .act_cc1(act_cc1), .act_bright(act_bright),
    .act_contrast(act_contrast), .act_hue(act_hue), .act_ugain(act_ugain),
    .act_vgain(act_vgain), .act_gamma_sel(act_gamma_sel)
  );

  // reference model built from the requirements
  logic [7:0] m_sh [NW];
  logic [7:0] m_act[NW];
  logic m_gsh, m_gact, m_en, m_pend, m_s1, m_s2, m_s3;

  function automatic logic [7:0] def_val(input int i);
    return (i == 3 || i == 5 || i == 6) ? 8'h80 : 8'h00;  // R1
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin m_sh[i] <= def_val(i); m_act[i] <= def_val(i); end
      m_gsh <= 0; m_gact <= 0; m_en <= 1; m_pend <= 0;
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
    end else begin
      logic cm, hit;
      cm  = m_s3 & ~m_s2;
      hit = wr_en && wr_addr >= 1 && wr_addr <= 8;
      m_s1 <= vsync_in; m_s2 <= m_s1; m_s3 <= m_s2;
      for (int i = 0; i < NW; i++) begin
        logic h;
        h = wr_en && wr_addr == 4'(i + 1);
        if (h) m_sh[i] <= wr_data;
        if (!m_en) m_act[i] <= h ? wr_data : m_sh[i];
        else if (cm) m_act[i] <= m_sh[i];
      end
      begin
        logic hg;
        hg = wr_en && wr_addr == 4'd8;
        if (hg) m_gsh <= wr_data[0];
        if (!m_en) m_gact <= hg ? wr_data[0] : m_gsh;
        else if (cm) m_gact <= m_gsh;
      end
      if (wr_en && wr_addr == 0) m_en <= wr_data[0];
      if (!m_en) m_pend <= 0;
      else if (hit) m_pend <= 1;
      else if (cm) m_pend <= 0;
    end
  end

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    if (a == 0) return {6'd0, m_pend, m_en};
    if (a == 8) return {7'd0, m_gsh};
    if (a >= 1 && a <= 7) return m_sh[a - 1];
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [7:0] a[NW];
    a[0] = act_cc0; a[1] = act_cc1; a[2] = act_bright; a[3] = act_contrast;
    a[4] = act_hue; a[5] = act_ugain; a[6] = act_vgain;
    for (int i = 0; i < NW; i++) chk(a[i] == m_act[i], tag, a[i], m_act[i]);
    chk(act_gamma_sel == m_gact, tag, act_gamma_sel, m_gact);
    chk(rd_data == exp_read(rd_addr), {tag, "/R8 read"}, rd_data, exp_read(rd_addr));
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(act_contrast == 8'h80 && act_ugain == 8'h80 && act_vgain == 8'h80, "R1 gains", act_contrast, 8'h80);
    chk(act_bright == 0 && act_hue == 0 && act_cc0 == 0 && act_gamma_sel == 0, "R1 zeros", act_bright, 0);
    rd_addr = 0; #1;
    chk(rd_data == 8'h01, "R1 ctrl", rd_data, 8'h01);

    // R3/R7: buffered write does not reach output, pending set
    write_reg(4'd3, 8'h55);
    rd_addr = 3; #1;
    chk(act_bright == 8'h00, "R3 held", act_bright, 0);
    chk(rd_data == 8'h55, "R8 shadow readback", rd_data, 8'h55);
    rd_addr = 0; #1;
    chk(rd_data == 8'h03, "R7 pending set", rd_data, 8'h03);
    // R2: rising vsync causes no load
    vsync_in = 1;
    repeat (4) @(negedge clk);
    chk(act_bright == 8'h00, "R2 rising ignored", act_bright, 0);
    // R2: falling edge loads at third rising edge
    vsync_in = 0;
    @(negedge clk); @(negedge clk);
    chk(act_bright == 8'h00, "R2 not yet", act_bright, 0);
    // write lands in the load cycle (R5)
    wr_en = 1; wr_addr = 4'd5; wr_data = 8'h3C;
    @(negedge clk); wr_en = 0;
    chk(act_bright == 8'h55, "R2 R4 loaded", act_bright, 8'h55);
    chk(act_hue == 8'h00, "R5 old value committed", act_hue, 0);
    rd_addr = 0; #1;
    chk(rd_data == 8'h03, "R7 pending kept by coincident write", rd_data, 8'h03);
    vsync_in = 1; repeat (4) @(negedge clk);
    vsync_in = 0; repeat (3) @(negedge clk);
    chk(act_hue == 8'h3C, "R5 next field", act_hue, 8'h3C);
    #1; chk(rd_data == 8'h01, "R7 pending cleared", rd_data, 8'h01);

    // R9 gamma keeps bit 0 only; R8 unmapped write ignored
    write_reg(4'd8, 8'hFE);
    rd_addr = 8; #1;
    chk(rd_data == 8'h00, "R9 gamma bit0", rd_data, 0);
    write_reg(4'd8, 8'h03);
    #1; chk(rd_data == 8'h01, "R9 gamma readback", rd_data, 1);
    write_reg(4'd12, 8'hAA);
    rd_addr = 12; #1;
    chk(rd_data == 8'h00, "R8 unmapped", rd_data, 0);
    chk_all("R8 unmapped write no effect");

    // R10: disabling pushes staged values; R6 immediate writes
    write_reg(4'd1, 8'h11);
    write_reg(4'd0, 8'h00);
    @(negedge clk);
    chk(act_cc0 == 8'h11 && act_gamma_sel == 1'b1, "R10 flush", act_cc0, 8'h11);
    @(negedge clk); wr_en = 1; wr_addr = 4'd7; wr_data = 8'h9A;
    @(negedge clk); wr_en = 0;
    chk(act_vgain == 8'h9A, "R6 bypass", act_vgain, 8'h9A);
    rd_addr = 0; #1;
    chk(rd_data == 8'h00, "R7 pending off", rd_data, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      chk_all(m_en ? "R3 R4 random" : "R6 R10 random");
      wr_en   = ($urandom % 4) == 0;
      wr_addr = 4'($urandom % 11);
      wr_data = 8'($urandom);
      if (wr_addr == 0) wr_data[0] = ($urandom % 6) != 0;
      if (($urandom % 15) == 0) vsync_in = ~vsync_in;
      rd_addr = 4'($urandom % 11);
    end
    @(negedge clk); wr_en = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule